// File: doc/BRIEF.md
# Edge-Tracking Receive Bit-Clock Recovery Loop

This block recovers a bit strobe and the sampled data bit from an NRZ serial stream. It uses a reference clock that runs at a fixed multiple of the bit rate. A phase counter wraps once per bit period, and the data is sampled when the counter reaches mid-period. The block starts in a hunting state. In that state the first data transition sets the counter directly. After that the loop tracks: each transition moves the phase by one count toward the expected transition position.

If the line stays quiet for longer than a programmable number of bit periods, the loop goes back to hunting. The next transition then snaps the phase again, so the loop can lock onto frames that have gaps between them. The counter keeps running when no transitions arrive, so strobes continue during idle lines and during reset recovery.

The block also reports a phase-error flag. It is refreshed only on transitions seen while tracking. A synchronous resync command forces hunting at any time.

Top module: `rx_dpll_top`

## Requirements
- R1: While reset is held high, `bit_stb` is 0, `phase_err` is 0 and `hunting` is 1.
- R2: With no data transitions, `bit_stb` pulses for one cycle every 16 clocks and is never high on two consecutive cycles.
- R3: The input passes through two registers. While hunting, a data change captured by the first register at clock edge k makes `hunting` low after edge k+1. It makes `bit_stb` high after edge k+9 with `rx_bit` equal to the new level, and no strobe occurs after edges k+2 to k+8 or k+10 to k+24.
- R4: The phase count p runs 0 to 15. The expected transition lies at 0 and sampling happens at 8. When a transition is seen while tracking at count p, the next count is p (hold) for p in 1..7 and p+2 modulo 16 for p in 9..15. It is p+1 for p equal to 0 or 8.
- R5: On each transition seen while tracking, `phase_err` becomes 1 if p is between 3 and 13 inclusive, and 0 otherwise. Transitions seen while hunting, edgeless stretches and the resync command leave it unchanged.
- R6: While tracking, every strobe cycle without a transition counts one bit period. The counter is cleared by any transition. `hunting` rises together with strobe number `gap_limit`*8+1 counted from the last transition, and a `gap_limit` of 0 acts as 1.
- R7: A transition that arrives in the same strobe cycle that would exceed the limit wins. The loop stays tracking and the count restarts from zero.
- R8: `resync_cmd` high for one cycle makes `hunting` 1 after that edge, clears the idle count and suppresses any snap in that cycle.
- R9: `rx_bit` holds the level of the synchronized data at the most recent sample point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock at 16 times the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| rx_din | input | 1 | Serial NRZ data in |
| resync_cmd | input | 1 | One-cycle command forcing the hunting state |
| gap_limit | input | 9 | Idle limit in units of 8 bit periods (0 treated as 1) |
| bit_stb | output | 1 | One-cycle recovered bit strobe |
| rx_bit | output | 1 | Recovered data bit, valid with `bit_stb` |
| hunting | output | 1 | 1 while waiting to snap phase to the next transition |
| phase_err | output | 1 | 1 when the last tracked transition fell outside the ±2 count window |

## Verification
A transition can arrive in exactly the strobe cycle where the idle counter would reach its limit. The timeout and the tracking update then compete. The bench provokes this with the limit set to 1: after lock, it places the second transition 136 clocks later, so it lands on phase count 8 of the ninth idle strobe. It expects `hunting` to stay low, `phase_err` to rise (count 8 is out of window), and a fresh nine-strobe timeout afterwards. A companion case puts the transition one bit period later and expects the timeout first and then a clean snap.

// File: rtl/rx_dpll_pkg.sv
package rx_dpll_pkg;
  typedef enum logic {
    LOOP_TRACK = 1'b0,
    LOOP_HUNT  = 1'b1
  } loop_mode_e;
endpackage

// File: rtl/rx_dpll_sync.sv
module rx_dpll_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout,
  output logic edge_det
);
  logic [STAGES-1:0] sr;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sr[0] <= 1'b0;
          else     sr[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sr[g] <= 1'b0;
          else     sr[g] <= sr[g-1];
        end
      end
    end
  endgenerate

  assign dout     = sr[STAGES-1];
  assign edge_det = sr[STAGES-1] ^ sr[STAGES-2];
endmodule

// File: rtl/rx_dpll_gap.sv
module rx_dpll_gap #(
  parameter int LIM_W     = 9,
  parameter int UNIT_LOG2 = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LIM_W-1:0] gap_limit,
  input  logic             strobe_cyc,
  input  logic             edge_det,
  input  logic             resync,
  input  logic             seek,
  output logic             expire
);
  localparam int CW = LIM_W + UNIT_LOG2;

  logic [LIM_W-1:0] lim_eff;
  logic [CW-1:0]    limit;
  logic [CW-1:0]    cnt;
  logic             at_limit;

  assign lim_eff  = (gap_limit == '0) ? LIM_W'(1) : gap_limit;
  assign limit    = {lim_eff, {UNIT_LOG2{1'b0}}};
  assign at_limit = (cnt >= limit);
  assign expire   = strobe_cyc && !edge_det && !seek && !resync && at_limit;

  always_ff @(posedge clk) begin
    if (rst || resync || edge_det) begin
      cnt <= '0;
    end else if (strobe_cyc && !seek && !at_limit) begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/rx_dpll_phase.sv
module rx_dpll_phase
  import rx_dpll_pkg::*;
#(
  parameter int OSR = 16,
  parameter int WIN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic edge_det,
  input  logic din_s,
  input  logic resync,
  input  logic expire,
  output logic strobe_cyc,
  output logic bit_stb,
  output logic rx_bit,
  output logic seek,
  output logic phase_err
);
  localparam int PW = $clog2(OSR);
  localparam logic [PW-1:0] SAMPLE = PW'(OSR / 2);
  localparam logic [PW-1:0] WIN_LO = PW'(WIN);
  localparam logic [PW-1:0] WIN_HI = PW'(OSR - WIN);

  loop_mode_e    mode;
  logic [PW-1:0] ph, ph_n;
  logic          in_win;
  logic          track_edge;

  assign strobe_cyc = (ph == SAMPLE);
  assign in_win     = (ph <= WIN_LO) || (ph >= WIN_HI);
  assign track_edge = edge_det && !resync && (mode == LOOP_TRACK);
  assign seek       = (mode == LOOP_HUNT);

  always_comb begin
    ph_n = ph + PW'(1);
    if (edge_det && !resync) begin
      if (mode == LOOP_HUNT)                ph_n = PW'(1);
      else if (ph == '0 || ph == SAMPLE)    ph_n = ph + PW'(1);
      else if (ph < SAMPLE)                 ph_n = ph;
      else                                  ph_n = ph + PW'(2);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= '0;
      mode      <= LOOP_HUNT;
      phase_err <= 1'b0;
      bit_stb   <= 1'b0;
      rx_bit    <= 1'b0;
    end else begin
      ph      <= ph_n;
      bit_stb <= strobe_cyc;
      if (strobe_cyc) rx_bit <= din_s;
      if (resync)        mode <= LOOP_HUNT;
      else if (edge_det) mode <= LOOP_TRACK;
      else if (expire)   mode <= LOOP_HUNT;
      if (track_edge) phase_err <= !in_win;
    end
  end
endmodule

// File: rtl/rx_dpll_top.sv
module rx_dpll_top #(
  parameter int OSR         = 16,
  parameter int WIN         = 2,
  parameter int LIM_W       = 9,
  parameter int UNIT_LOG2   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_din,
  input  logic             resync_cmd,
  input  logic [LIM_W-1:0] gap_limit,
  output logic             bit_stb,
  output logic             rx_bit,
  output logic             hunting,
  output logic             phase_err
);
  logic din_s;
  logic edge_det;
  logic strobe_cyc;
  logic expire;

  rx_dpll_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .din      (rx_din),
    .dout     (din_s),
    .edge_det (edge_det)
  );

  rx_dpll_phase #(.OSR(OSR), .WIN(WIN)) u_phase (
    .clk        (clk),
    .rst        (rst),
    .edge_det   (edge_det),
    .din_s      (din_s),
    .resync     (resync_cmd),
    .expire     (expire),
    .strobe_cyc (strobe_cyc),
    .bit_stb    (bit_stb),
    .rx_bit     (rx_bit),
    .seek       (hunting),
    .phase_err  (phase_err)
  );

  rx_dpll_gap #(.LIM_W(LIM_W), .UNIT_LOG2(UNIT_LOG2)) u_gap (
    .clk        (clk),
    .rst        (rst),
    .gap_limit  (gap_limit),
    .strobe_cyc (strobe_cyc),
    .edge_det   (edge_det),
    .resync     (resync_cmd),
    .seek       (hunting),
    .expire     (expire)
  );
endmodule

// File: rtl/rx_dpll_chk.sv
module rx_dpll_chk (
  input logic clk,
  input logic rst,
  input logic edge_det,
  input logic resync_cmd,
  input logic bit_stb,
  input logic hunting,
  input logic phase_err
);
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
    bit_stb |=> !bit_stb); // R2

  AST_HUNT_SNAP: assert property (@(posedge clk) disable iff (rst)
    (hunting && edge_det && !resync_cmd) |=> !hunting); // R3

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!edge_det || hunting) |=> $stable(phase_err)); // R5

  AST_HUNT_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
    $rose(hunting) |-> (bit_stb || $past(resync_cmd))); // R6

  AST_EDGE_KEEPS_LOCK: assert property (@(posedge clk) disable iff (rst)
    (!hunting && edge_det && !resync_cmd) |=> !hunting); // R7

  AST_RESYNC_HUNT: assert property (@(posedge clk) disable iff (rst)
    resync_cmd |=> hunting); // R8
endmodule

bind rx_dpll_top rx_dpll_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .edge_det   (edge_det),
  .resync_cmd (resync_cmd),
  .bit_stb    (bit_stb),
  .hunting    (hunting),
  .phase_err  (phase_err)
);

// File: tb/rx_dpll_top_tb.sv
module rx_dpll_top_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_din = 1'b0;
  logic       resync_cmd = 1'b0;
  logic [8:0] gap_limit = 9'd4;
  logic       bit_stb, rx_bit, hunting, phase_err;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  rx_dpll_top u_dut (
    .clk(clk), .rst(rst), .rx_din(rx_din), .resync_cmd(resync_cmd),
    .gap_limit(gap_limit), .bit_stb(bit_stb), .rx_bit(rx_bit),
    .hunting(hunting), .phase_err(phase_err)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    rx_din = 1'b0;
    resync_cmd = 1'b0;
    step();
    step();
    rst = 1'b0;
  endtask

  // toggle line while hunting and check the snap timing (R3, R9)
  task automatic snap_check(input string tag);
    int bad = 0;
    rx_din = ~rx_din;
    for (int i = 1; i <= 26; i++) begin
      step();
      if (i == 2 && hunting !== 1'b0) bad++;
      if (((i >= 3 && i <= 9) || (i >= 11 && i <= 25)) && bit_stb !== 1'b0) bad++;
      if (i == 10) begin
        chk(bit_stb === 1'b1 && rx_bit === rx_din, {tag, " R9 sampled bit"}, int'(rx_bit), int'(rx_din));
        if (bit_stb !== 1'b1) bad++;
      end
      if (i == 26 && bit_stb !== 1'b1) bad++;
    end
    chk(bad == 0, {tag, " R3 snap timing"}, bad, 0);
  endtask

  initial begin : main
    int cnt;
    int first;
    int idx;
    do_reset();
    // R1 reset state, sampled while reset held
    rst = 1'b1;
    step();
    chk(bit_stb === 1'b0 && hunting === 1'b1 && phase_err === 1'b0, "R1 reset state",
        int'({bit_stb, hunting, phase_err}), 3'b010);
    rst = 1'b0;

    // R2 free running strobes
    cnt = 0; first = -1; idx = 0;
    for (int i = 1; i <= 64; i++) begin
      step();
      if (bit_stb === 1'b1) begin
        if (first >= 0) chk(i - idx == 16, "R2 strobe spacing", i - idx, 16);
        if (first < 0) first = i;
        idx = i;
        cnt++;
      end
    end
    chk(cnt == 4, "R2 strobe count", cnt, 4);

    // R3 snap from every phase offset
    for (int off = 0; off < 16; off++) begin
      do_reset();
      for (int i = 0; i < off; i++) step();
      snap_check($sformatf("off%0d", off));
    end

    // R4 / R5 tracking sweep
    for (int T = 10; T <= 30; T++) begin
      int p, s, m, exp_d, got_d, phm;
      bit exp_err;
      do_reset();
      gap_limit = 9'd4;
      rx_din = ~rx_din;
      for (int i = 0; i < T; i++) step();
      rx_din = ~rx_din;
      p = T % 16;
      s = (p >= 1 && p <= 7) ? -1 : ((p >= 9) ? 1 : 0);
      m = T;
      phm = p;
      while (phm != 8) begin
        m++;
        phm = (((m + s) % 16) + 16) % 16;
      end
      exp_d = m + 2 - T;
      step();
      got_d = -1;
      for (int i = 2; i <= 40; i++) begin
        step();
        if (got_d < 0 && bit_stb === 1'b1) got_d = i;
      end
      chk(got_d == exp_d, $sformatf("R4 strobe delay p=%0d", p), got_d, exp_d);
      exp_err = (p >= 3 && p <= 13);
      chk(phase_err === exp_err && hunting === 1'b0, $sformatf("R5 window p=%0d", p),
          int'(phase_err), int'(exp_err));
    end

    // R6 idle timeout for several limits, 0 acting as 1
    for (int lim = 0; lim <= 4; lim++) begin
      int ord, exp_o;
      bit prev_h;
      do_reset();
      gap_limit = 9'(lim);
      rx_din = ~rx_din;
      step(); step();
      ord = 0; cnt = 0; prev_h = 1'b0;
      for (int i = 3; i <= 700; i++) begin
        step();
        if (bit_stb === 1'b1) cnt++;
        if (hunting === 1'b1) begin
          ord = (bit_stb === 1'b1) ? cnt : -1;
          break;
        end
      end
      exp_o = ((lim == 0) ? 1 : lim) * 8 + 1;
      chk(ord == exp_o, $sformatf("R6 timeout limit=%0d", lim), ord, exp_o);
    end

    // R7 transition coinciding with the expiring strobe
    do_reset();
    gap_limit = 9'd1;
    rx_din = ~rx_din;
    for (int i = 0; i < 136; i++) step();
    chk(hunting === 1'b0, "R7 still tracking before coincidence", int'(hunting), 0);
    rx_din = ~rx_din;
    step(); step();
    chk(bit_stb === 1'b1 && hunting === 1'b0, "R7 edge wins over timeout",
        int'({bit_stb, hunting}), 2'b10);
    chk(phase_err === 1'b1, "R7 R5 count 8 out of window", int'(phase_err), 1);
    cnt = 0; idx = -1;
    for (int i = 3; i <= 200; i++) begin
      step();
      if (bit_stb === 1'b1) cnt++;
      if (hunting === 1'b1) begin idx = cnt; break; end
    end
    chk(idx == 9, "R7 idle count restarted", idx, 9);

    // R6 timeout first, then clean snap one bit period later
    do_reset();
    gap_limit = 9'd1;
    rx_din = ~rx_din;
    for (int i = 0; i < 152; i++) step();
    chk(hunting === 1'b1, "R6 expired before late edge", int'(hunting), 1);
    snap_check("late");

    // R8 resync, with R5 flag retention
    do_reset();
    gap_limit = 9'd4;
    rx_din = ~rx_din;
    for (int i = 0; i < 20; i++) step();
    rx_din = ~rx_din;
    for (int i = 0; i < 30; i++) step();
    chk(phase_err === 1'b1, "R5 flag set p=4", int'(phase_err), 1);
    resync_cmd = 1'b1;
    step();
    resync_cmd = 1'b0;
    chk(hunting === 1'b1, "R8 resync forces hunting", int'(hunting), 1);
    chk(phase_err === 1'b1, "R5 flag kept over resync", int'(phase_err), 1);
    snap_check("resync");
    chk(phase_err === 1'b1, "R5 flag kept over hunting snap", int'(phase_err), 1);
    for (int i = 0; i < 700; i++) step();
    chk(hunting === 1'b1 && phase_err === 1'b1, "R5 flag kept over idle run",
        int'({hunting, phase_err}), 2'b11);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule